// File: doc/BRIEF.md
# Colour Lookup Table Register Block

This block holds a colour lookup table for an indexed-colour display. There are 256 main entries for pseudocolour pixels and 4 overlay entries for a hardware cursor. Each entry is an 8-bit red, green and blue triple. Software reaches the table through a 32-bit register window that decodes bus address bits 3:2. Colour bytes always travel in bits 31:24 of the bus word.

Software first writes an entry number to the index register. It then moves one colour byte per access, always in red, green, blue order. A single phase counter tracks the component, and reads and writes share it. After the blue component the index moves to the next entry by itself, so a whole run of entries can be loaded or dumped without touching the index again.

The display pipeline has a separate lookup port. It returns the full 24-bit colour of any entry one cycle after the address is presented. Main entries sit at lookup addresses 0 to 255 and the overlay entries at 256 to 259.

Top module: `clut_regfile`

## Requirements
- R1: After reset every entry is zero except entries 255, 256 and 258, which are white (0xFFFFFF). The index is 0 and the phase is red.
- R2: A write at offset code 2'b00 loads the index from wdata[31:24] and sets the phase to red. The other data bits are ignored.
- R3: A write at offset code 2'b01 stores wdata[31:24] into the current component of main entry [index]. The other components and the other entries are unchanged.
- R4: Every colour access (a read at any offset, or a write at offset code 2'b01 or 2'b11) advances the phase: red to green to blue. An access in blue phase returns the phase to red and increments the index.
- R5: A write at offset code 2'b11 stores wdata[31:24] into overlay entry (index mod 4), which is lookup address 256 + (index mod 4). The main entries are unchanged, and the index and phase advance as in R4.
- R6: A read returns the current component of main entry [index] in rdata[31:24], with rdata[23:0] zero. The value appears in the cycle after the read strobe and is held until the next read.
- R7: A write at offset code 2'b10 changes no entry, no index and no phase.
- R8: The lookup port returns {R[23:16], G[15:8], B[7:0]} of entry lk_addr one cycle after the address is presented. Addresses 260 to 511 return zero.
- R9: Incrementing the index from 255 gives 0.
- R10: An index write in the middle of a sequence restarts the phase at red. The next colour access then hits the red component.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register access strobe, one cycle per access |
| reg_write | input | 1 | 1 for write, 0 for read |
| reg_off | input | 2 | Address bits 3:2 of the access |
| reg_wdata | input | 32 | Write data; colour and index in bits 31:24 |
| reg_rdata | output | 32 | Read data, registered |
| lk_addr | input | 9 | Lookup entry address |
| lk_rgb | output | 24 | Lookup colour, one cycle latency |

## Verification
The hardest situation to reach from the ports is the shared phase counter sitting part-way through a triple when a different kind of access arrives. Examples are a read interleaved into a write sequence, an overlay write following main writes, or an index reload in mid-sequence. Only some of these shift which component later bytes land in.

The stimulus mixes all access kinds at random. Index values are skewed toward 252 to 255 so that wraps occur often. Directed cases pin down the mid-sequence reload and the ignored offset. Afterwards a full lookup sweep compares every entry with the bench model.

// File: rtl/clut_pkg.sv
package clut_pkg;

    // Component phase shared by reads and writes
    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } phase_e;

    // Decoded values of address bits 3:2
    localparam logic [1:0] OFF_INDEX = 2'b00;
    localparam logic [1:0] OFF_MAIN  = 2'b01;
    localparam logic [1:0] OFF_SPARE = 2'b10;
    localparam logic [1:0] OFF_OVL   = 2'b11;

endpackage

// File: rtl/clut_seq.sv
module clut_seq
    import clut_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idx_ld,
    input  logic [IDX_W-1:0] idx_val,
    input  logic             acc_adv,
    output logic [IDX_W-1:0] idx_q,
    output phase_e           ph_q
);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        phase_e           ph;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (idx_ld) begin
            seq_d.idx = idx_val;
            seq_d.ph  = PH_RED;
        end else if (acc_adv) begin
            unique case (seq_q.ph)
                PH_RED:  seq_d.ph = PH_GRN;
                PH_GRN:  seq_d.ph = PH_BLU;
                default: begin
                    seq_d.ph  = PH_RED;
                    seq_d.idx = seq_q.idx + 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{idx: '0, ph: PH_RED};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign idx_q = seq_q.idx;
    assign ph_q  = seq_q.ph;

    // R4
    phase_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q inside {PH_RED, PH_GRN, PH_BLU});

    // R4
    blue_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_adv && !idx_ld && ph_q == PH_BLU) |=>
        (idx_q == IDX_W'($past(idx_q) + 1'b1)) && (ph_q == PH_RED));

endmodule

// File: rtl/clut_store.sv
module clut_store
    import clut_pkg::*;
#(
    parameter int IDX_W   = 8,
    parameter int NUM_OVL = 4,
    parameter int CH_W    = 8,
    localparam int NUM_MAIN = 1 << IDX_W,
    localparam int NUM_ENT  = NUM_MAIN + NUM_OVL,
    localparam int ENT_W    = $clog2(NUM_ENT),
    localparam int RGB_W    = 3 * CH_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [ENT_W-1:0] we_ent,
    input  phase_e           we_ph,
    input  logic [CH_W-1:0]  we_byte,
    input  logic [IDX_W-1:0] rd_idx,
    input  phase_e           rd_ph,
    output logic [CH_W-1:0]  rd_byte,
    input  logic [ENT_W-1:0] lk_addr,
    output logic [RGB_W-1:0] lk_rgb
);

    function automatic logic [CH_W-1:0] comp_of(input logic [RGB_W-1:0] rgb,
                                                input phase_e ph);
        unique case (ph)
            PH_RED:  comp_of = rgb[3*CH_W-1 -: CH_W];
            PH_GRN:  comp_of = rgb[2*CH_W-1 -: CH_W];
            default: comp_of = rgb[CH_W-1:0];
        endcase
    endfunction

    logic [RGB_W-1:0] ent_d [NUM_ENT];
    logic [RGB_W-1:0] ent_q [NUM_ENT];
    logic [RGB_W-1:0] lk_d, lk_q;

    always_comb begin
        for (int e = 0; e < NUM_ENT; e++) begin
            ent_d[e] = ent_q[e];
            if (we && we_ent == ENT_W'(e)) begin
                unique case (we_ph)
                    PH_RED:  ent_d[e][3*CH_W-1 -: CH_W] = we_byte;
                    PH_GRN:  ent_d[e][2*CH_W-1 -: CH_W] = we_byte;
                    default: ent_d[e][CH_W-1:0]         = we_byte;
                endcase
            end
        end
        lk_d = (lk_addr < ENT_W'(NUM_ENT)) ? ent_q[lk_addr] : '0;
    end

    // One register per entry; three of them reset to white
    for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
        localparam bit WHITE = (e == NUM_MAIN - 1) || (e == NUM_MAIN) ||
                               (e == NUM_MAIN + 2);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q[e] <= WHITE ? {RGB_W{1'b1}} : {RGB_W{1'b0}};
            end else begin
                ent_q[e] <= ent_d[e];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_q <= '0;
        end else begin
            lk_q <= lk_d;
        end
    end

    assign rd_byte = comp_of(ent_q[ENT_W'(rd_idx)], rd_ph);
    assign lk_rgb  = lk_q;

    // R3
    wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> comp_of(ent_q[$past(we_ent)], $past(we_ph)) == $past(we_byte));

    // R8
    lk_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_addr >= ENT_W'(NUM_ENT)) |=> (lk_rgb == '0));

endmodule

// File: rtl/clut_regfile.sv
module clut_regfile
    import clut_pkg::*;
#(
    parameter int IDX_W   = 8,
    parameter int NUM_OVL = 4,
    parameter int CH_W    = 8,
    parameter int BUS_W   = 32,
    localparam int NUM_MAIN = 1 << IDX_W,
    localparam int NUM_ENT  = NUM_MAIN + NUM_OVL,
    localparam int ENT_W    = $clog2(NUM_ENT),
    localparam int OVL_W    = $clog2(NUM_OVL),
    localparam int RGB_W    = 3 * CH_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_valid,
    input  logic             reg_write,
    input  logic [1:0]       reg_off,
    input  logic [BUS_W-1:0] reg_wdata,
    output logic [BUS_W-1:0] reg_rdata,
    input  logic [ENT_W-1:0] lk_addr,
    output logic [RGB_W-1:0] lk_rgb
);

    typedef struct packed {
        logic [BUS_W-1:0] rdata;
    } top_t;

    top_t top_d, top_q;

    logic             wr_idx, wr_main, wr_ovl, wr_spare, rd_acc, acc_adv;
    logic [IDX_W-1:0] idx_q;
    phase_e           ph_q;
    logic [ENT_W-1:0] we_ent;
    logic [CH_W-1:0]  rd_byte;
    logic             unused_low;

    assign unused_low = ^reg_wdata[BUS_W-CH_W-1:0];

    always_comb begin
        wr_idx   = reg_valid && reg_write && (reg_off == OFF_INDEX);
        wr_main  = reg_valid && reg_write && (reg_off == OFF_MAIN);
        wr_ovl   = reg_valid && reg_write && (reg_off == OFF_OVL);
        wr_spare = reg_valid && reg_write && (reg_off == OFF_SPARE);
        rd_acc   = reg_valid && !reg_write;
        acc_adv  = wr_main || wr_ovl || rd_acc;
        we_ent   = wr_ovl ? ENT_W'(NUM_MAIN) + ENT_W'(idx_q[OVL_W-1:0])
                          : ENT_W'(idx_q);
        top_d    = top_q;
        if (rd_acc) begin
            top_d.rdata = {rd_byte, {(BUS_W-CH_W){1'b0}}};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign reg_rdata = top_q.rdata;

    clut_seq #(.IDX_W(IDX_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx_ld  (wr_idx),
        .idx_val (reg_wdata[BUS_W-1 -: IDX_W]),
        .acc_adv (acc_adv),
        .idx_q   (idx_q),
        .ph_q    (ph_q)
    );

    clut_store #(.IDX_W(IDX_W), .NUM_OVL(NUM_OVL), .CH_W(CH_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_main || wr_ovl),
        .we_ent  (we_ent),
        .we_ph   (ph_q),
        .we_byte (reg_wdata[BUS_W-1 -: CH_W]),
        .rd_idx  (idx_q),
        .rd_ph   (ph_q),
        .rd_byte (rd_byte),
        .lk_addr (lk_addr),
        .lk_rgb  (lk_rgb)
    );

    // R2
    idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_idx |=> (idx_q == $past(reg_wdata[BUS_W-1 -: IDX_W])) && (ph_q == PH_RED));

    // R7
    spare_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_spare |=> $stable(idx_q) && $stable(ph_q));

    // R6
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_acc |=> $stable(reg_rdata));

endmodule

// File: tb/clut_regfile_bench.sv
`timescale 1ns/1ps
module clut_regfile_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_valid = 1'b0;
    logic        reg_write = 1'b0;
    logic [1:0]  reg_off = 2'b00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [8:0]  lk_addr = '0;
    logic [23:0] lk_rgb;

    always #2 clk = ~clk;

    clut_regfile u_clut_regfile (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_valid (reg_valid),
        .reg_write (reg_write),
        .reg_off   (reg_off),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .lk_addr   (lk_addr),
        .lk_rgb    (lk_rgb)
    );

    int tests = 0;
    int fails = 0;
    bit done = 0;

    // Bench model
    logic [7:0] m_rgb [260][3];
    int m_idx;
    int m_ph;

    function automatic logic [23:0] model_rgb(input int a);
        if (a < 260) return {m_rgb[a][0], m_rgb[a][1], m_rgb[a][2]};
        return 24'h0;
    endfunction

    function automatic void model_reset();
        for (int e = 0; e < 260; e++)
            for (int c = 0; c < 3; c++)
                m_rgb[e][c] = (e == 255 || e == 256 || e == 258) ? 8'hFF : 8'h00;
        m_idx = 0;
        m_ph  = 0;
    endfunction

    function automatic void model_adv();
        if (m_ph == 2) begin
            m_ph  = 0;
            m_idx = (m_idx + 1) % 256;
        end else begin
            m_ph = m_ph + 1;
        end
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_op(input logic wr, input logic [1:0] off, input logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1;
        reg_write = wr;
        reg_off   = off;
        reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0;
        reg_write = 1'b0;
    endtask

    task automatic do_write(input logic [1:0] off, input logic [31:0] d);
        bus_op(1'b1, off, d);
        case (off)
            2'b00: begin m_idx = int'(d[31:24]); m_ph = 0; end
            2'b01: begin m_rgb[m_idx][m_ph] = d[31:24]; model_adv(); end
            2'b11: begin m_rgb[256 + (m_idx % 4)][m_ph] = d[31:24]; model_adv(); end
            default: ;
        endcase
    endtask

    task automatic do_read(input string req);
        logic [31:0] exp;
        exp = {m_rgb[m_idx][m_ph], 24'h0};
        bus_op(1'b0, 2'($urandom_range(0, 3)), 32'h0);
        check(reg_rdata === exp, req, reg_rdata, exp);
        model_adv();
    endtask

    task automatic do_lookup(input int a, input string req);
        logic [23:0] exp;
        @(negedge clk);
        lk_addr = 9'(a);
        @(negedge clk);
        exp = model_rgb(a);
        check(lk_rgb === exp, req, {8'h0, lk_rgb}, {8'h0, exp});
    endtask

    task automatic sweep(input string req);
        for (int a = 0; a < 260; a++) do_lookup(a, req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset contents, index 0, phase red
        sweep("R1");
        // R8: out-of-range lookups
        do_lookup(260, "R8");
        do_lookup(300, "R8");
        do_lookup(511, "R8");
        do_read("R1 R6 idx0 red");

        // R9: index 255, read triple then wrap to 0
        do_write(2'b00, 32'hFF00_1234);
        do_read("R6 R9");
        do_read("R6 R9");
        do_read("R6 R9");
        do_read("R9 wrap to entry 0");

        // R3 R4: a full triple into entry 7, then auto-advance to 8
        do_write(2'b00, 32'h0700_0000);
        do_write(2'b01, 32'h11AB_CDEF);
        do_write(2'b01, 32'h2200_0000);
        do_write(2'b01, 32'h33FF_FFFF);
        do_write(2'b01, 32'h4400_0000);
        do_lookup(7, "R3 R4");
        do_lookup(8, "R4 advance");

        // R10: mid-sequence index reload restarts at red
        do_write(2'b00, 32'h1400_0000);
        do_write(2'b01, 32'hAA00_0000);
        do_write(2'b00, 32'h1400_0000);
        do_write(2'b01, 32'hBB00_0000);
        do_lookup(20, "R10");

        // R5: overlay writes via index 0x45 -> overlay 1 (lookup 257)
        do_write(2'b00, 32'h4500_0000);
        do_write(2'b11, 32'h1200_0000);
        do_write(2'b11, 32'h3400_0000);
        do_write(2'b11, 32'h5600_0000);
        do_write(2'b11, 32'h7800_0000);
        do_lookup(257, "R5");
        do_lookup(258, "R5 advance");
        do_lookup(69, "R5 main untouched");

        // R7: spare offset changes nothing
        do_write(2'b00, 32'h3000_0000);
        do_write(2'b01, 32'h5500_0000);
        do_write(2'b10, 32'hEE00_0000);
        do_write(2'b01, 32'h6600_0000);
        do_lookup(48, "R7");
        do_read("R7 phase kept");

        // R4 R6: read interleaved with writes
        do_write(2'b00, 32'h3100_0000);
        do_write(2'b01, 32'h0100_0000);
        do_read("R4 shared phase");
        do_write(2'b01, 32'h0300_0000);
        do_lookup(49, "R4 shared phase");

        // Random mix
        for (int n = 0; n < 4000; n++) begin
            int k;
            k = $urandom_range(0, 99);
            if (k < 10) begin
                logic [7:0] iv;
                iv = ($urandom_range(0, 1) == 1) ? 8'($urandom_range(252, 255))
                                                 : 8'($urandom);
                do_write(2'b00, {iv, 24'($urandom)});
            end else if (k < 45) begin
                do_write(2'b01, $urandom);
            end else if (k < 60) begin
                do_write(2'b11, $urandom);
            end else if (k < 65) begin
                do_write(2'b10, $urandom);
            end else begin
                do_read("R6 random");
            end
        end
        sweep("R3 R5 random");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule